// File: doc/BRIEF.md
# SMBus Target Register Interface

This block is a synchronous target for a two-wire system management bus. The system clock samples both bus lines. The block drives the data line only through an active-high pull-low enable. It watches for START, repeated START and STOP conditions and compares each address byte against a fixed 7-bit device address. It then gives the bus host single-byte access to an external register file through a register pointer that persists between transactions.

Four host transactions are carried out:

- **Write Byte:** loads the pointer, then writes one data byte.
- **Send Byte:** loads the pointer only.
- **Receive Byte:** reads the register at the current pointer.
- **Read Byte:** a pointer load, then a repeated START, then a one-byte read.

A read at the alert response address returns the device address. It is acknowledged only while the alert-pending input is high. All other traffic is left unanswered and does not change any register.

The register file sits outside the block. It sees the pointer, the received data byte and a single-cycle write pulse, and it returns the addressed byte combinationally. The block makes no assumption about the SCL period. Every action is tied to synchronised SCL edges, so a stretched or irregular clock is handled the same as a regular one.

Top module: `smb_target`

## Requirements
- R1: After reset, `sdaOe` is 0, `regWe` is 0 and `regAddr` is 8'h00.
- R2: Write Byte (START, device address with bit 0 = 0, command byte, data byte) is handled as follows. Each of the three bytes is acknowledged by pulling SDA low in its ninth clock. Exactly one `regWe` pulse follows, after the ACK clock of the data byte, carrying `regAddr` = command and `regWdata` = data.
- R3: Send Byte (START, device address with bit 0 = 0, command byte, STOP) sets `regAddr` to the command byte and produces no `regWe` pulse.
- R4: Receive Byte (START, device address with bit 0 = 1) acknowledges the address. It then shifts out the register at the current pointer, MSB first, with each bit valid while SCL is high. It leaves SDA to the host in the ninth clock.
- R5: Read Byte (Write-form address, command, repeated START, Read-form address, one byte, host NACK, STOP) returns the register at the new command byte.
- R6: A byte whose upper 7 bits match neither address is not acknowledged. SDA is then never pulled low until the next START, and no register or pointer changes.
- R7: A read at address 7'b0001100 is acknowledged only while `alertPending` is 1. It returns the device address in bits 7:1 and 0 in bit 0 (8'h98 for the default device address 7'h4C).
- R8: A START arriving part-way through the data byte of a Write Byte aborts the transaction without a `regWe` pulse.
- R9: A STOP arriving part-way through the data byte of a Write Byte aborts the transaction without a `regWe` pulse.
- R10: Transactions behave identically for SCL low times from 8 to 40 clock cycles. SDA is changed by the block only after a falling SCL edge, or after a START or STOP.
- R11: A further byte after the data byte of a Write Byte is not acknowledged and causes no second write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sclIn | input | 1 | Bus clock line as seen at the pin |
| sdaIn | input | 1 | Bus data line as seen at the pin |
| alertPending | input | 1 | High while an alert is waiting to be claimed |
| regRdata | input | 8 | Register file read data at `regAddr` |
| sdaOe | output | 1 | When 1, pulls the data line low |
| regAddr | output | 8 | Register pointer |
| regWdata | output | 8 | Byte to be written |
| regWe | output | 1 | Single-cycle register write strobe |

## Verification
A wrong controller state shows up at the ports within one bus bit. The first sign is a missing or spurious pull-low in an ACK clock, or a read bit that differs from the addressed register. A corrupted pointer or a stray write strobe stays hidden until a later read. For that reason the stimulus writes to several addresses and reads them back, including after aborted transactions. An ACK sampled by the bus model in the ninth clock of every byte exposes an address decoder or bit counter that is off by one. Varying the SCL low time catches any logic that depends on a fixed bit period rather than on synchronised edges.

// File: rtl/smb_target_pkg.sv
package smb_target_pkg;

  localparam int BYTE_W = 8;
  localparam int CNT_W  = $clog2(BYTE_W + 1);

  typedef enum logic [3:0] {
    S_IDLE,
    S_ADDR,
    S_ADDR_ACK,
    S_CMD,
    S_CMD_ACK,
    S_DATA,
    S_DATA_ACK,
    S_TX,
    S_TX_ACK,
    S_WAIT
  } busState_t;

  typedef struct packed {
    logic rxEn;
    logic cntClr;
    logic ptrLoad;
    logic txLoadReg;
    logic txLoadAra;
    logic txShift;
    logic wrStb;
  } ctlStb_t;

endpackage

// File: rtl/smb_datapath.sv
module smb_datapath
  import smb_target_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR    = 7'h4C,
  parameter int         SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclIn,
  input  logic              sdaIn,
  input  ctlStb_t           ctl,
  input  logic [BYTE_W-1:0] regRdata,
  output logic              sclS,
  output logic              sclFall,
  output logic              startDet,
  output logic              stopDet,
  output logic              byteDone,
  output logic [CNT_W-1:0]  bitCnt,
  output logic [BYTE_W-1:0] rxByte,
  output logic              txBit,
  output logic [BYTE_W-1:0] regAddr,
  output logic [BYTE_W-1:0] regWdata,
  output logic              regWe
);

  localparam logic [BYTE_W-1:0] ARA_REPLY = {DEV_ADDR, 1'b0};

  logic [SYNC_STAGES-1:0] sclChain;
  logic [SYNC_STAGES-1:0] sdaChain;
  logic                   sdaS;
  logic                   sclD;
  logic                   sdaD;
  logic                   sclRise;
  logic [BYTE_W-1:0]      txReg;
  logic [BYTE_W-1:0]      ptr;

  // Two (or more) flop synchronisers; the bus idles high.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclChain <= '1;
      sdaChain <= '1;
      sclD     <= 1'b1;
      sdaD     <= 1'b1;
    end else begin
      sclChain <= {sclChain[SYNC_STAGES-2:0], sclIn};
      sdaChain <= {sdaChain[SYNC_STAGES-2:0], sdaIn};
      sclD     <= sclS;
      sdaD     <= sdaS;
    end
  end

  assign sclS     = sclChain[SYNC_STAGES-1];
  assign sdaS     = sdaChain[SYNC_STAGES-1];
  assign sclRise  = sclS & ~sclD;
  assign sclFall  = ~sclS & sclD;
  assign startDet = sclS & sclD & sdaD & ~sdaS;
  assign stopDet  = sclS & sclD & ~sdaD & sdaS;
  assign byteDone = (bitCnt == CNT_W'(BYTE_W));

  // Bit counter and receive shifter, sampled on rising SCL.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bitCnt <= '0;
      rxByte <= '0;
    end else if (ctl.cntClr) begin
      bitCnt <= '0;
    end else if (ctl.rxEn && sclRise && !byteDone) begin
      rxByte <= {rxByte[BYTE_W-2:0], sdaS};
      bitCnt <= bitCnt + 1'b1;
    end else if (ctl.txShift) begin
      bitCnt <= bitCnt + 1'b1;
    end
  end

  // Transmit shifter, MSB first.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      txReg <= '1;
    end else if (ctl.txLoadReg) begin
      txReg <= regRdata;
    end else if (ctl.txLoadAra) begin
      txReg <= ARA_REPLY;
    end else if (ctl.txShift) begin
      txReg <= {txReg[BYTE_W-2:0], 1'b1};
    end
  end

  assign txBit = txReg[BYTE_W-1];

  // Persistent register pointer.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr <= '0;
    end else if (ctl.ptrLoad) begin
      ptr <= rxByte;
    end
  end

  assign regAddr  = ptr;
  assign regWdata = rxByte;
  assign regWe    = ctl.wrStb;

  AST_PTR_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ptr) |-> $past(sclFall)); // R3

  AST_WE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    regWe |=> !regWe); // R2

  AST_WE_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    regWe |-> !sclS); // R10

endmodule

// File: rtl/smb_control.sv
module smb_control
  import smb_target_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h4C,
  parameter logic [6:0] ARA_ADDR = 7'h0C
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclS,
  input  logic              sclFall,
  input  logic              startDet,
  input  logic              stopDet,
  input  logic              byteDone,
  input  logic [CNT_W-1:0]  bitCnt,
  input  logic [BYTE_W-1:0] rxByte,
  input  logic              txBit,
  input  logic              alertPending,
  output ctlStb_t           ctl,
  output logic              sdaOe
);

  busState_t state;
  busState_t stateNxt;
  logic      isRead;
  logic      isReadNxt;
  logic      isAra;
  logic      isAraNxt;
  logic      devHit;
  logic      araHit;

  assign devHit = (rxByte[BYTE_W-1:1] == DEV_ADDR);
  assign araHit = (rxByte[BYTE_W-1:1] == ARA_ADDR) && rxByte[0] && alertPending;

  always_comb begin
    stateNxt  = state;
    isReadNxt = isRead;
    isAraNxt  = isAra;
    ctl       = '0;
    if (startDet) begin
      stateNxt   = S_ADDR;
      ctl.cntClr = 1'b1;
    end else if (stopDet) begin
      stateNxt   = S_IDLE;
      ctl.cntClr = 1'b1;
    end else begin
      unique case (state)
        S_ADDR: begin
          ctl.rxEn = 1'b1;
          if (sclFall && byteDone) begin
            ctl.cntClr = 1'b1;
            if (devHit) begin
              stateNxt      = S_ADDR_ACK;
              isReadNxt     = rxByte[0];
              isAraNxt      = 1'b0;
              ctl.txLoadReg = rxByte[0];
            end else if (araHit) begin
              stateNxt      = S_ADDR_ACK;
              isReadNxt     = 1'b1;
              isAraNxt      = 1'b1;
              ctl.txLoadAra = 1'b1;
            end else begin
              stateNxt = S_WAIT;
            end
          end
        end
        S_ADDR_ACK: begin
          if (sclFall) begin
            ctl.cntClr = 1'b1;
            stateNxt   = isRead ? S_TX : S_CMD;
          end
        end
        S_CMD: begin
          ctl.rxEn = 1'b1;
          if (sclFall && byteDone) begin
            ctl.cntClr  = 1'b1;
            ctl.ptrLoad = 1'b1;
            stateNxt    = S_CMD_ACK;
          end
        end
        S_CMD_ACK: begin
          if (sclFall) stateNxt = S_DATA;
        end
        S_DATA: begin
          ctl.rxEn = 1'b1;
          if (sclFall && byteDone) begin
            ctl.cntClr = 1'b1;
            stateNxt   = S_DATA_ACK;
          end
        end
        S_DATA_ACK: begin
          if (sclFall) begin
            ctl.wrStb = 1'b1;
            stateNxt  = S_WAIT;
          end
        end
        S_TX: begin
          if (sclFall) begin
            if (bitCnt == CNT_W'(BYTE_W - 1)) stateNxt = S_TX_ACK;
            else ctl.txShift = 1'b1;
          end
        end
        S_TX_ACK: begin
          if (sclFall) stateNxt = S_WAIT;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= S_IDLE;
      isRead <= 1'b0;
      isAra  <= 1'b0;
    end else begin
      state  <= stateNxt;
      isRead <= isReadNxt;
      isAra  <= isAraNxt;
    end
  end

  assign sdaOe = (state == S_ADDR_ACK) || (state == S_CMD_ACK) ||
                 (state == S_DATA_ACK) || ((state == S_TX) && !txBit);

  AST_OE_SCL_LOW_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(sclS) && !$past(startDet) && !$past(stopDet)) |-> $stable(sdaOe)); // R10

  AST_ARA_NEEDS_ALERT: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_ADDR_ACK && isAra && $past(state) == S_ADDR) |-> $past(alertPending)); // R7

  AST_NO_DRIVE_AFTER_MISS: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(state) == S_WAIT && !$past(startDet)) |-> !sdaOe); // R6

endmodule

// File: rtl/smb_target.sv
module smb_target
  import smb_target_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR    = 7'h4C,
  parameter logic [6:0] ARA_ADDR    = 7'h0C,
  parameter int         SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        sclIn,
  input  logic        sdaIn,
  input  logic        alertPending,
  input  logic [7:0]  regRdata,
  output logic        sdaOe,
  output logic [7:0]  regAddr,
  output logic [7:0]  regWdata,
  output logic        regWe
);

  ctlStb_t           ctl;
  logic              sclS;
  logic              sclFall;
  logic              startDet;
  logic              stopDet;
  logic              byteDone;
  logic [CNT_W-1:0]  bitCnt;
  logic [BYTE_W-1:0] rxByte;
  logic              txBit;

  smb_datapath #(
    .DEV_ADDR   (DEV_ADDR),
    .SYNC_STAGES(SYNC_STAGES)
  ) i_datapath (
    .clk     (clk),
    .rst_n   (rst_n),
    .sclIn   (sclIn),
    .sdaIn   (sdaIn),
    .ctl     (ctl),
    .regRdata(regRdata),
    .sclS    (sclS),
    .sclFall (sclFall),
    .startDet(startDet),
    .stopDet (stopDet),
    .byteDone(byteDone),
    .bitCnt  (bitCnt),
    .rxByte  (rxByte),
    .txBit   (txBit),
    .regAddr (regAddr),
    .regWdata(regWdata),
    .regWe   (regWe)
  );

  smb_control #(
    .DEV_ADDR(DEV_ADDR),
    .ARA_ADDR(ARA_ADDR)
  ) i_control (
    .clk         (clk),
    .rst_n       (rst_n),
    .sclS        (sclS),
    .sclFall     (sclFall),
    .startDet    (startDet),
    .stopDet     (stopDet),
    .byteDone    (byteDone),
    .bitCnt      (bitCnt),
    .rxByte      (rxByte),
    .txBit       (txBit),
    .alertPending(alertPending),
    .ctl         (ctl),
    .sdaOe       (sdaOe)
  );

endmodule

// File: tb/test_smb_target.sv
module test_smb_target;

  localparam logic [7:0] DEV_W = 8'h98;
  localparam logic [7:0] DEV_R = 8'h99;

  typedef struct packed {
    logic       rd;
    logic [7:0] cmd;
    logic [7:0] data;
    logic [5:0] lowT;
  } vec_t;

  localparam vec_t VECS [8] = '{
    '{1'b0, 8'h10, 8'hA5, 6'd10},
    '{1'b0, 8'h11, 8'h3C, 6'd24},
    '{1'b0, 8'hFF, 8'h81, 6'd8},
    '{1'b1, 8'h10, 8'hA5, 6'd40},
    '{1'b1, 8'h11, 8'h3C, 6'd9},
    '{1'b0, 8'h10, 8'h5E, 6'd12},
    '{1'b1, 8'h10, 8'h5E, 6'd30},
    '{1'b1, 8'hFF, 8'h81, 6'd16}
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sclHost = 1'b1;
  logic       sdaHost = 1'b1;
  logic       alertPending = 1'b0;
  logic       sdaOe;
  logic       sdaBus;
  logic [7:0] regAddr;
  logic [7:0] regWdata;
  logic [7:0] regRdata;
  logic       regWe;
  logic [7:0] regMem [256];
  int         weCount = 0;
  int         oeCount = 0;
  int         nChk = 0;
  int         nErr = 0;
  int         lowT = 10;
  int         highT = 8;

  always #5 clk = ~clk;

  assign sdaBus   = sdaHost & ~sdaOe;
  assign regRdata = regMem[regAddr];

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 256; i++) regMem[i] <= 8'h00;
    end else if (regWe) begin
      regMem[regAddr] <= regWdata;
    end
    if (regWe) weCount <= weCount + 1;
    if (sdaOe) oeCount <= oeCount + 1;
  end

  smb_target i_smb_target (
    .clk         (clk),
    .rst_n       (rst_n),
    .sclIn       (sclHost),
    .sdaIn       (sdaBus),
    .alertPending(alertPending),
    .regRdata    (regRdata),
    .sdaOe       (sdaOe),
    .regAddr     (regAddr),
    .regWdata    (regWdata),
    .regWe       (regWe)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nErr++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic waitCyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic busStart();
    waitCyc(lowT / 2);
    sdaHost = 1'b1;
    waitCyc(lowT - lowT / 2);
    sclHost = 1'b1;
    waitCyc(highT);
    sdaHost = 1'b0;
    waitCyc(highT);
    sclHost = 1'b0;
  endtask

  task automatic busStop();
    waitCyc(lowT / 2);
    sdaHost = 1'b0;
    waitCyc(lowT - lowT / 2);
    sclHost = 1'b1;
    waitCyc(highT);
    sdaHost = 1'b1;
    waitCyc(highT);
  endtask

  task automatic putBit(input logic b);
    waitCyc(lowT / 2);
    sdaHost = b;
    waitCyc(lowT - lowT / 2);
    sclHost = 1'b1;
    waitCyc(highT);
    sclHost = 1'b0;
  endtask

  task automatic getBit(output logic b);
    waitCyc(lowT / 2);
    sdaHost = 1'b1;
    waitCyc(lowT - lowT / 2);
    sclHost = 1'b1;
    waitCyc(highT / 2);
    b = sdaBus;
    waitCyc(highT - highT / 2);
    sclHost = 1'b0;
  endtask

  task automatic sendByte(input logic [7:0] v, output logic ack);
    for (int i = 7; i >= 0; i--) putBit(v[i]);
    getBit(ack);
  endtask

  task automatic readByte(input logic hostAck, output logic [7:0] v);
    logic b;
    v = '0;
    for (int i = 0; i < 8; i++) begin
      getBit(b);
      v = {v[6:0], b};
    end
    putBit(hostAck);
  endtask

  task automatic doWrite(input logic [7:0] cmd, input logic [7:0] data, output logic [2:0] acks);
    busStart();
    sendByte(DEV_W, acks[2]);
    sendByte(cmd, acks[1]);
    sendByte(data, acks[0]);
    busStop();
  endtask

  task automatic doRead(input logic [7:0] cmd, output logic [2:0] acks, output logic [7:0] v);
    busStart();
    sendByte(DEV_W, acks[2]);
    sendByte(cmd, acks[1]);
    busStart();
    sendByte(DEV_R, acks[0]);
    readByte(1'b1, v);
    busStop();
  endtask

  task automatic doReceive(output logic ack, output logic [7:0] v);
    busStart();
    sendByte(DEV_R, ack);
    readByte(1'b1, v);
    busStop();
  endtask

  initial begin
    logic [2:0] acks;
    logic       ack;
    logic [7:0] v;
    int         weBase;
    int         oeBase;

    waitCyc(5);
    rst_n = 1'b1;
    waitCyc(3);
    // R1: reset state
    chk("R1 sdaOe", 32'(sdaOe), 32'd0);
    chk("R1 regWe", 32'(regWe), 32'd0);
    chk("R1 regAddr", 32'(regAddr), 32'h00);

    // Table of Write Byte / Read Byte vectors at varying SCL low times (R10)
    foreach (VECS[k]) begin
      lowT = int'(VECS[k].lowT);
      weBase = weCount;
      if (!VECS[k].rd) begin
        doWrite(VECS[k].cmd, VECS[k].data, acks);
        waitCyc(2);
        chk("R2 R10 write acks", 32'(acks), 32'd0);
        chk("R2 write strobe count", 32'(weCount - weBase), 32'd1);
        chk("R2 written value", 32'(regMem[VECS[k].cmd]), 32'(VECS[k].data));
      end else begin
        doRead(VECS[k].cmd, acks, v);
        chk("R5 R10 read acks", 32'(acks), 32'd0);
        chk("R5 R10 read data", 32'(v), 32'(VECS[k].data));
        chk("R5 no write", 32'(weCount - weBase), 32'd0);
      end
    end
    lowT = 10;

    // R3: Send Byte moves pointer only
    weBase = weCount;
    busStart();
    sendByte(DEV_W, acks[1]);
    sendByte(8'h11, acks[0]);
    busStop();
    chk("R3 acks", 32'(acks[1:0]), 32'd0);
    chk("R3 pointer", 32'(regAddr), 32'h11);
    chk("R3 no write", 32'(weCount - weBase), 32'd0);

    // R4: Receive Byte at current pointer
    doReceive(ack, v);
    chk("R4 ack", 32'(ack), 32'd0);
    chk("R4 data", 32'(v), 32'h3C);

    // R6: foreign address ignored
    weBase = weCount;
    oeBase = oeCount;
    busStart();
    sendByte(8'h66, acks[2]);
    sendByte(8'h10, acks[1]);
    sendByte(8'h00, acks[0]);
    busStop();
    chk("R6 no ack", 32'(acks), 32'd7);
    chk("R6 never driven", 32'(oeCount - oeBase), 32'd0);
    chk("R6 no write", 32'(weCount - weBase), 32'd0);
    chk("R6 pointer kept", 32'(regAddr), 32'h11);

    // R7: alert response address without and with pending alert
    oeBase = oeCount;
    alertPending = 1'b0;
    busStart();
    sendByte(8'h19, ack);
    busStop();
    chk("R7 no ack without alert", 32'(ack), 32'd1);
    chk("R7 never driven", 32'(oeCount - oeBase), 32'd0);
    alertPending = 1'b1;
    busStart();
    sendByte(8'h19, ack);
    readByte(1'b1, v);
    busStop();
    alertPending = 1'b0;
    chk("R7 ack with alert", 32'(ack), 32'd0);
    chk("R7 reply", 32'(v), 32'h98);

    // R8: START in the middle of the data byte
    weBase = weCount;
    busStart();
    sendByte(DEV_W, acks[1]);
    sendByte(8'h10, acks[0]);
    putBit(1'b1); putBit(1'b0); putBit(1'b1); putBit(1'b0);
    busStart();
    busStop();
    chk("R8 no write", 32'(weCount - weBase), 32'd0);
    doReceive(ack, v);
    chk("R8 register kept", 32'(v), 32'h5E);

    // R9: STOP in the middle of the data byte
    weBase = weCount;
    busStart();
    sendByte(DEV_W, acks[1]);
    sendByte(8'hFF, acks[0]);
    putBit(1'b0); putBit(1'b0); putBit(1'b1); putBit(1'b1); putBit(1'b0);
    busStop();
    chk("R9 no write", 32'(weCount - weBase), 32'd0);
    doReceive(ack, v);
    chk("R9 register kept", 32'(v), 32'h81);

    // R11: extra byte after Write Byte
    weBase = weCount;
    busStart();
    sendByte(DEV_W, acks[2]);
    sendByte(8'h20, acks[1]);
    sendByte(8'h77, acks[0]);
    sendByte(8'h55, ack);
    busStop();
    waitCyc(2);
    chk("R11 first acks", 32'(acks), 32'd0);
    chk("R11 extra nack", 32'(ack), 32'd1);
    chk("R11 one write", 32'(weCount - weBase), 32'd1);
    chk("R11 value", 32'(regMem[8'h20]), 32'h77);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nErr);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    nChk++;
    nErr++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nErr);
    $finish;
  end

endmodule